// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block controls a one-time-programmable array of 128 words of 32 bits each. Software reaches it through a simple register bus with one write strobe and one read strobe. Read data comes back one cycle after the read strobe. The bus exposes a control register, two aliases of it that set or clear bits, a timing register and a data register. It also exposes a window of shadow registers, one for each fuse word. The array itself is a behavioural register array inside the block, and every bit reads as intact after reset.

Programming is guarded. Software first places the unlock key in the control register together with a word address, then writes the data register. The controller latches the address, masks the data with the bits of that word that are already blown, and walks through the word serially. For each bit it runs an idle period, a strobe pulse and a second idle period. The data register shifts right after every bit. A guard period follows the last bit before the controller accepts a new operation.

A reload request copies every fuse word into its shadow register, one word at a time. Per-word lock bitmaps (read lock and write lock) come in as inputs. Any lock violation sets a sticky error flag, and that flag refuses all further requests until software clears it.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the control register, timing register, data register and every shadow register read 0, and every fuse bit is unblown.
- R2: The timing register at 0x10 keeps bits [21:0] and reads the other bits as 0. Its fields are STROBE_PROG in [11:0], RELAX in [15:12] and STROBE_READ in [21:16]. The control register at 0x00 holds the word address in [6:0] and the key field in [31:16]. A write to 0x04 ORs the written value into these fields, and a write to 0x08 clears the bits that are written as 1.
- R3: A data-register (0x20) write made while the key field holds 0x3E77, with BUSY (control bit 8) low and ERROR (bit 9) low, starts programming. The controller latches the word address and raises BUSY, and the key field reads 0 on the next cycle. An address written during the operation does not change which word is programmed.
- R4: When programming starts, the data register holds the new data ANDed with the inverse of the current fuse word. Only bits that are 1 in this value get blown.
- R5: Once per bit period the data register shifts right and fills with 0. Data-register writes have no effect while programming runs.
- R6: Programming keeps BUSY high for exactly 32·(2·(RELAX+1)+STROBE_PROG+1)+GUARD_CYC cycles after the launching write.
- R7: A program request to a word whose write-lock bit is set blows nothing and leaves BUSY low. It sets ERROR and clears the key field.
- R8: While ERROR is set, program requests, reload requests and shadow writes are refused, and shadow reads return 0xBADABADA. ERROR stays set until a write of 1 to bit 9 at 0x08.
- R9: A shadow read of a word whose read-lock bit is set returns 0xBADABADA and sets ERROR.
- R10: A shadow write to an unlocked word stores the value when no reload is running. A shadow write to a write-locked word, or any shadow write during a reload, sets ERROR and leaves the shadow unchanged.
- R11: Writing 1 to bit 10 at 0x04 starts a reload. The reload copies fuse word n into the shadow at 0x400+0x10·n. Bit 10 and BUSY stay high for NWORDS·(STROBE_READ+1) cycles. Shadows do not follow the fuses until a reload runs.
- R12: A data-register write made without the key only loads the data register. It does not start programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rd_lock | input | NWORDS | Per-word read-lock bitmap |
| wr_lock | input | NWORDS | Per-word write-lock bitmap |

## Verification
The bench programs a word twice with overlapping data. A design that skipped the mask would show the full second value in the data register, not the remainder, and a design that shifted at the wrong moment would show the wrong value at the exact cycles sampled. It moves the address field in the middle of an operation. A design without an internal address copy would blow the wrong word, and only a reload reveals that. It samples BUSY and the reload bit on the last cycle of each operation and on the cycle after it, so a counter that is off by one shows at once. It also raises each lock violation and then tries a program, a reload and a shadow write while ERROR is set. A design that did not treat ERROR as sticky would let one of these through, and it would show in the shadows after the flag is cleared.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
  localparam int WORD_W = 32;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_SET    = 12'h004;
  localparam logic [11:0] OFS_CLR    = 12'h008;
  localparam logic [11:0] OFS_TIME   = 12'h010;
  localparam logic [11:0] OFS_DATA   = 12'h020;
  localparam logic [11:0] OFS_SHADOW = 12'h400;

  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_WORD = 32'hBADABADA;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;

  typedef struct packed {
    logic [5:0]  strobe_read;
    logic [3:0]  relax;
    logic [11:0] strobe_prog;
  } fuse_timing_t;

  // Does a bus address land on a shadow word of an array of nwords?
  function automatic logic is_shadow(logic [11:0] a, int nwords);
    logic [11:0] off;
    off = a - OFS_SHADOW;
    return (a >= OFS_SHADOW) && (a[3:0] == 4'h0) && (int'(off[11:4]) < nwords);
  endfunction

  function automatic int shadow_index(logic [11:0] a);
    logic [11:0] off;
    off = a - OFS_SHADOW;
    return int'(off[11:4]);
  endfunction

  // Cycles spent on one fuse bit: idle, strobe, idle.
  function automatic int bit_cycles(fuse_timing_t t);
    return 2 * (int'(t.relax) + 1) + int'(t.strobe_prog) + 1;
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array import fusectl_pkg::*; #(
  parameter int NWORDS = 128,
  localparam int AW = $clog2(NWORDS),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blow_en,
  input  logic [AW-1:0]     blow_addr,
  input  logic [BW-1:0]     blow_bit,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [WORD_W-1:0] rd_b_data
);
  logic [WORD_W-1:0] mem [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (blow_en) begin
      mem[blow_addr][blow_bit] <= 1'b1;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq import fusectl_pkg::*; #(
  parameter int NWORDS    = 128,
  parameter int GUARD_CYC = 16,
  localparam int AW = $clog2(NWORDS),
  localparam int BW = $clog2(WORD_W),
  localparam int CW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_prog,
  input  logic         start_reload,
  input  fuse_timing_t timing,
  output logic         busy,
  output logic         reloading,
  output logic         blow_evt,
  output logic         shift_evt,
  output logic         copy_evt,
  output logic [AW-1:0] copy_idx,
  output logic [BW-1:0] bit_idx
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_STROBE, S_POST, S_GUARD, S_RELOAD} seq_st_t;
  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          relax_done, strobe_done, guard_done, read_done;

  assign relax_done  = (cnt == CW'(timing.relax));
  assign strobe_done = (cnt == CW'(timing.strobe_prog));
  assign read_done   = (cnt == CW'(timing.strobe_read));
  assign guard_done  = (cnt == CW'(GUARD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      copy_idx <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_prog) begin
            st      <= S_PRE;
            bit_idx <= '0;
          end else if (start_reload) begin
            st       <= S_RELOAD;
            copy_idx <= '0;
          end
        end
        S_PRE: begin
          cnt <= relax_done ? '0 : cnt + 1'b1;
          if (relax_done) st <= S_STROBE;
        end
        S_STROBE: begin
          cnt <= strobe_done ? '0 : cnt + 1'b1;
          if (strobe_done) st <= S_POST;
        end
        S_POST: begin
          cnt <= relax_done ? '0 : cnt + 1'b1;
          if (relax_done) begin
            if (bit_idx == BW'(WORD_W - 1)) st <= S_GUARD;
            else begin
              bit_idx <= bit_idx + 1'b1;
              st      <= S_PRE;
            end
          end
        end
        S_GUARD: begin
          cnt <= guard_done ? '0 : cnt + 1'b1;
          if (guard_done) st <= S_IDLE;
        end
        S_RELOAD: begin
          cnt <= read_done ? '0 : cnt + 1'b1;
          if (read_done) begin
            if (copy_idx == AW'(NWORDS - 1)) st <= S_IDLE;
            else copy_idx <= copy_idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign reloading = (st == S_RELOAD);
  assign blow_evt  = (st == S_STROBE) && strobe_done;
  assign shift_evt = (st == S_POST) && relax_done;
  assign copy_evt  = (st == S_RELOAD) && read_done;
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl import fusectl_pkg::*; #(
  parameter int NWORDS    = 128,
  parameter int GUARD_CYC = 16,
  localparam int AW = $clog2(NWORDS),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [11:0]       bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NWORDS-1:0] rd_lock,
  input  logic [NWORDS-1:0] wr_lock
);
  logic [AW-1:0]     addr_q, prog_addr_q, sh_idx, copy_idx;
  logic [15:0]       key_q;
  logic              error_q;
  fuse_timing_t      timing_q;
  logic [WORD_W-1:0] data_q, rdata_q, fuse_cur, fuse_copy;
  logic [WORD_W-1:0] shadow [NWORDS];
  logic [BW-1:0]     bit_idx;
  logic              seq_busy, reloading, blow_evt, shift_evt, copy_evt;

  // Named decode events (also observed by the checker)
  logic wr_ctrl, wr_set, wr_clr, wr_time, wr_data, sh_hit;
  logic prog_req, prog_start, lock_reject, data_load, reload_start;
  logic sh_wr_ok, sh_wr_bad, sh_rd_bad, clr_err;
  logic [WORD_W-1:0] ctrl_view;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_set  = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr  = bus_wr && (bus_addr == OFS_CLR);
  assign wr_time = bus_wr && (bus_addr == OFS_TIME);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign sh_hit  = is_shadow(bus_addr, NWORDS);
  assign sh_idx  = AW'(shadow_index(bus_addr));

  assign prog_req     = wr_data && !seq_busy && !error_q && (key_q == UNLOCK_KEY);
  assign lock_reject  = prog_req && wr_lock[addr_q];
  assign prog_start   = prog_req && !wr_lock[addr_q];
  assign data_load    = wr_data && !seq_busy && !error_q && (key_q != UNLOCK_KEY);
  assign reload_start = wr_set && bus_wdata[BIT_RELOAD] && !seq_busy && !error_q;
  assign sh_wr_bad    = bus_wr && sh_hit && (wr_lock[sh_idx] || reloading || error_q);
  assign sh_wr_ok     = bus_wr && sh_hit && !sh_wr_bad;
  assign sh_rd_bad    = bus_rd && sh_hit && (rd_lock[sh_idx] || error_q);
  assign clr_err      = wr_clr && bus_wdata[BIT_ERR];

  assign ctrl_view = {key_q, 5'b0, reloading, error_q, seq_busy, 1'b0, 7'(addr_q)};

  fuse_array #(.NWORDS(NWORDS)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .blow_en  (blow_evt && data_q[0]),
    .blow_addr(prog_addr_q),
    .blow_bit (bit_idx),
    .rd_a_addr(addr_q),
    .rd_a_data(fuse_cur),
    .rd_b_addr(copy_idx),
    .rd_b_data(fuse_copy)
  );

  fuse_seq #(.NWORDS(NWORDS), .GUARD_CYC(GUARD_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_prog  (prog_start),
    .start_reload(reload_start),
    .timing      (timing_q),
    .busy        (seq_busy),
    .reloading   (reloading),
    .blow_evt    (blow_evt),
    .shift_evt   (shift_evt),
    .copy_evt    (copy_evt),
    .copy_idx    (copy_idx),
    .bit_idx     (bit_idx)
  );

  // Control, timing and error state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      key_q       <= '0;
      error_q     <= 1'b0;
      timing_q    <= '0;
      prog_addr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        addr_q <= bus_wdata[AW-1:0];
        key_q  <= bus_wdata[31:16];
      end else if (wr_set) begin
        addr_q <= addr_q | bus_wdata[AW-1:0];
        key_q  <= key_q | bus_wdata[31:16];
      end else if (wr_clr) begin
        addr_q <= addr_q & ~bus_wdata[AW-1:0];
        key_q  <= key_q & ~bus_wdata[31:16];
      end else if (prog_req) begin
        key_q <= '0;
      end
      if (prog_start) prog_addr_q <= addr_q;
      if (wr_time) timing_q <= bus_wdata[21:0];
      if (lock_reject || sh_wr_bad || sh_rd_bad) error_q <= 1'b1;
      else if (clr_err) error_q <= 1'b0;
    end
  end

  // Data register: load, masked launch, serial shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (prog_start) data_q <= bus_wdata & ~fuse_cur;
    else if (data_load) data_q <= bus_wdata;
    else if (shift_evt) data_q <= data_q >> 1;
  end

  // Shadow window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow[i] <= '0;
    end else if (copy_evt) begin
      shadow[copy_idx] <= fuse_copy;
    end else if (sh_wr_ok) begin
      shadow[sh_idx] <= bus_wdata;
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) begin
      if (bus_addr == OFS_CTRL || bus_addr == OFS_SET || bus_addr == OFS_CLR)
        rdata_q <= ctrl_view;
      else if (bus_addr == OFS_TIME) rdata_q <= WORD_W'(timing_q);
      else if (bus_addr == OFS_DATA) rdata_q <= data_q;
      else if (sh_hit) rdata_q <= sh_rd_bad ? LOCKED_WORD : shadow[sh_idx];
      else rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk import fusectl_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_start,
  input logic              lock_reject,
  input logic              reload_start,
  input logic              clr_err,
  input logic              seq_busy,
  input logic              reloading,
  input logic              error_q,
  input logic              blow_evt,
  input logic              shift_evt,
  input logic              copy_evt,
  input logic [WORD_W-1:0] data_q,
  input logic [15:0]       key_q
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> seq_busy && (key_q == 16'h0)); // R3
  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, reload_start, lock_reject})); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy && !reloading && !shift_evt |=> $stable(data_q)); // R5
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !data_q[WORD_W-1]); // R5
  AST_BLOW_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    blow_evt |-> seq_busy && !reloading); // R6
  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_reject |=> error_q && !seq_busy); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error_q && !clr_err |=> error_q); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    error_q |-> !prog_start && !reload_start); // R8
  AST_COPY_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |-> reloading && seq_busy); // R11
endmodule

bind fuse_ctl fuse_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_start  (prog_start),
  .lock_reject (lock_reject),
  .reload_start(reload_start),
  .clr_err     (clr_err),
  .seq_busy    (seq_busy),
  .reloading   (reloading),
  .error_q     (error_q),
  .blow_evt    (blow_evt),
  .shift_evt   (shift_evt),
  .copy_evt    (copy_evt),
  .data_q      (data_q),
  .key_q       (key_q)
);

// File: tb/tb_fuse_ctl.sv
module tb_fuse_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NW    = 128;
  localparam int GUARD = 16;
  localparam int RLX   = 1;
  localparam int SPRG  = 2;
  localparam int SRD   = 1;
  localparam logic [31:0] TIMING_VAL = 32'h0001_1002;
  localparam int PROG_LEN   = 32 * (2 * (RLX + 1) + SPRG + 1) + GUARD;
  localparam int RELOAD_LEN = NW * (SRD + 1);
  localparam logic [31:0] BAD = 32'hBADABADA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NW-1:0] rd_lock = '0, wr_lock = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fuse_ctl #(.NWORDS(NW), .GUARD_CYC(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_lock(rd_lock), .wr_lock(wr_lock)
  );

  function automatic logic [11:0] sh(int n);
    return 12'(12'h400 + 16 * n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Each bus op occupies exactly one clock edge, starting after a negedge.
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    logic [31:0] c;
    for (int i = 0; i < 5000; i++) begin
      rd(12'h000, c);
      if (c[8] == 1'b0 && c[10] == 1'b0) return;
    end
    check({req, " wait idle"}, c, 32'h0);
  endtask

  task automatic reload_all();
    wr(12'h004, 32'h400);
    wait_idle("R11");
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); check("R1 ctrl", d, 32'h0);
    rd(12'h010, d); check("R1 timing", d, 32'h0);
    rd(12'h020, d); check("R1 data", d, 32'h0);
    rd(sh(0), d);   check("R1 shadow0", d, 32'h0);
    rd(sh(127), d); check("R1 shadow127", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, d); check("R2 timing mask", d, 32'h003F_FFFF);
    wr(12'h010, TIMING_VAL);    rd(12'h010, d); check("R2 timing", d, TIMING_VAL);
    wr(12'h000, 32'h1234_0045); rd(12'h000, d); check("R2 ctrl", d, 32'h1234_0045);
    wr(12'h004, 32'h0000_0002); rd(12'h000, d); check("R2 set alias", d, 32'h1234_0047);
    wr(12'h008, 32'h1234_0000); rd(12'h000, d); check("R2 clear alias", d, 32'h0000_0047);
    wr(12'h000, 32'h0);
  endtask

  task automatic t_nokey();
    logic [31:0] d;
    wr(12'h020, 32'hDEAD_BEEF);
    rd(12'h000, d); check("R12 no busy", d, 32'h0);
    rd(12'h020, d); check("R12 data loaded", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_program();
    logic [31:0] d;
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_00F0);               // launch at E0
    rd(12'h000, d); check("R3 launch ctrl", d, 32'h0000_0105);   // E1
    idle(PROG_LEN - 2);
    rd(12'h000, d); check("R6 busy last cycle", d & 32'h100, 32'h100); // E_T
    rd(12'h000, d); check("R6 busy cleared", d, 32'h0000_0005);        // E_T+1
    rd(sh(5), d);   check("R11 shadow before reload", d, 32'h0);
    rd(12'h020, d); check("R5 zero fill", d, 32'h0);
    wr(12'h004, 32'h400);                     // reload at E0
    rd(12'h000, d); check("R11 reload ctrl", d, 32'h0000_0505);
    idle(RELOAD_LEN - 2);
    rd(12'h000, d); check("R11 reload last cycle", d & 32'h400, 32'h400);
    rd(12'h000, d); check("R11 reload done", d, 32'h0000_0005);
    rd(sh(5), d);   check("R11 shadow5 copied", d, 32'h0000_00F0);
    rd(sh(0), d);   check("R11 shadow0 copied", d, 32'h0);
    // second program, overlapping bits
    wr(12'h000, 32'h3E77_0005);
    wr(12'h020, 32'h0000_00FF);               // E0
    rd(12'h020, d); check("R4 masked data", d, 32'h0000_000F); // E1
    idle(5);
    rd(12'h020, d); check("R5 before first shift", d, 32'h0000_000F); // E7
    rd(12'h020, d); check("R5 after first shift", d, 32'h0000_0007);  // E8
    wr(12'h020, 32'hFFFF_FFFF);               // E9, ignored
    rd(12'h020, d); check("R5 write ignored", d, 32'h0000_0007);      // E10
    wait_idle("R6");
    reload_all();
    rd(sh(5), d); check("R4 only ones blown", d, 32'h0000_00FF);
  endtask

  task automatic t_redirect();
    logic [31:0] d;
    wr(12'h000, 32'h3E77_0007);
    wr(12'h020, 32'h0000_00A5);
    wr(12'h000, 32'h0000_0009);
    wait_idle("R3");
    rd(12'h000, d); check("R3 addr field moved", d, 32'h0000_0009);
    reload_all();
    rd(sh(7), d); check("R3 latched word", d, 32'h0000_00A5);
    rd(sh(9), d); check("R3 other word untouched", d, 32'h0);
  endtask

  task automatic t_wrlock();
    logic [31:0] d;
    wr_lock[3] = 1'b1;
    wr(12'h000, 32'h3E77_0003);
    wr(12'h020, 32'h0000_0001);
    rd(12'h000, d); check("R7 locked program", d, 32'h0000_0203);
    wr(12'h004, 32'h400);
    rd(12'h000, d); check("R8 reload refused", d, 32'h0000_0203);
    wr(sh(20), 32'h77);
    rd(sh(20), d); check("R8 shadow read refused", d, BAD);
    wr(12'h000, 32'h3E77_000A);
    wr(12'h020, 32'h0000_0003);
    rd(12'h000, d); check("R8 program refused", d, 32'h3E77_020A);
    wr(12'h008, 32'h200);
    rd(12'h000, d); check("R8 error cleared", d, 32'h3E77_000A);
    rd(sh(20), d); check("R8 shadow write refused", d, 32'h0);
    wr(12'h000, 32'h0);
    wr_lock[3] = 1'b0;
    reload_all();
    rd(sh(3), d);  check("R7 locked word intact", d, 32'h0);
    rd(sh(10), d); check("R8 refused word intact", d, 32'h0);
  endtask

  task automatic t_rdlock();
    logic [31:0] d;
    rd_lock[5] = 1'b1;
    rd(sh(5), d);   check("R9 locked read value", d, BAD);
    rd(12'h000, d); check("R9 error set", d, 32'h0000_0200);
    wr(12'h008, 32'h200);
    rd_lock[5] = 1'b0;
    rd(sh(5), d);   check("R9 unlocked read", d, 32'h0000_00FF);
  endtask

  task automatic t_shadow_wr();
    logic [31:0] d;
    wr(sh(30), 32'h1234);
    rd(sh(30), d);  check("R10 shadow write", d, 32'h1234);
    wr_lock[31] = 1'b1;
    wr(sh(31), 32'h5678);
    rd(12'h000, d); check("R10 locked shadow error", d, 32'h0000_0200);
    wr(12'h008, 32'h200);
    rd(sh(31), d);  check("R10 locked shadow intact", d, 32'h0);
    wr_lock[31] = 1'b0;
    wr(12'h004, 32'h400);                     // reload at E0; word0 copied at E2
    idle(4);
    wr(sh(0), 32'h55);                        // E5
    rd(12'h000, d); check("R10 write during reload", d, 32'h0000_0700);
    wr(12'h008, 32'h200);
    wait_idle("R10");
    rd(sh(0), d);   check("R10 reload write dropped", d, 32'h0);
    rd(sh(30), d);  check("R11 reload overwrites", d, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regmap();
    t_nokey();
    t_program();
    t_redirect();
    t_wrlock();
    t_rdlock();
    t_shadow_wr();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule